// File: doc/BRIEF.md
# Quad DAC Serial Register Front-End

This block is the digital input section of a four-channel converter with 12-bit codes. A host shifts a 16-bit word in, one bit at a time, on a shift clock made by ORing a frame-enable pin with a bit-clock pin. A rising edge on either pin can advance the register, so the two pins are interchangeable.

Each channel has two registers in series. A per-channel staging strobe copies the shift register's code field into one staging register, chosen by the word's address field. A global commit strobe passes all four staging registers into the output code registers together. Both strobes act as level-sensitive transparency: the target follows its source while the strobe is low and holds it while the strobe is high. An active-low preset pin forces every staging and output register to zero-scale or to mid-scale, depending on a mode pin, and leaves the shift register untouched.

All pins are sampled on a fast system clock through two-flop synchronizers. Edges on the combined shift clock are found from the sampled values, and transparency is carried out as one register update on each system clock while the strobe is low. Each channel's output code is driven on a shared bus, together with a one-cycle change pulse for that channel.

Top module: `qdac_serial_frontend`

## Requirements
- R1: While the system reset `rst_n` is low, every output code is 0x000 and every `upd_o` bit is 0.
- R2: The shift register holds the last 16 bits received. Bits [15:14] are the channel address (first bit sent = bit 15). Bits [13:12] are ignored. Bits [11:0] are the code, sent most significant bit first. Address 0 selects channel 0 (`code_o[11:0]`), 1 selects channel 1 (`code_o[23:12]`), 2 selects channel 2 and 3 selects channel 3 (`code_o[47:36]`).
- R3: The shift register moves one place, taking in `bit_dat_i`, on each rising edge of (`frame_n_i` OR `bit_clk_i`), and at no other time. Clocking with `frame_n_i` while `bit_clk_i` is held low works the same way as clocking with `bit_clk_i`. Raising `frame_n_i` while `bit_clk_i` is low adds one extra shift.
- R4: While `stage_n_i` is low, the staging register selected by the current address field follows the code field. While it is high, every staging register holds its value.
- R5: While `commit_n_i` is low, every output code follows its staging register. While it is high, the outputs hold, so staged data does not show until commit.
- R6: While `preset_n_i` is low, every staging and output register is set to 0x000 if `preset_mid_i` is low, or to 0x800 if it is high. The shift register contents survive a preset.
- R7: When preset is released with both strobes high, all registers keep the preset value.
- R8: If bits are shifted while `stage_n_i` is low, each channel the address field passes through is overwritten with the partial contents of the shift register.
- R9: `upd_o[i]` is 1 in exactly those cycles in which channel i's output code differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low asynchronous system reset, released synchronously |
| frame_n_i | input | 1 | Frame enable, active low; ORed with the bit clock |
| bit_clk_i | input | 1 | Serial bit clock |
| bit_dat_i | input | 1 | Serial data |
| stage_n_i | input | 1 | Staging strobe, active low, makes the addressed staging register transparent |
| commit_n_i | input | 1 | Commit strobe, active low, makes all output registers transparent |
| preset_n_i | input | 1 | Active-low preset of the staging and output registers |
| preset_mid_i | input | 1 | Preset value select: 0 gives 0x000, 1 gives 0x800 |
| code_o | output | 48 | Four 12-bit output codes, channel i at bits [12*i+11:12*i] |
| upd_o | output | 4 | One-cycle change pulse per channel |

## Verification
The bench goes after the corner cases that break this kind of front-end. One is the extra shift caused when frame enable rises with the bit clock low; a design that edge-detected only the bit clock would load the unshifted word into the wrong channel. Another is a staging strobe held low while shifting; a design that latched only at strobe release would miss the channels corrupted along the way. The bench also checks that the shift register survives a preset, which a design resetting it would fail by loading zero. Finally, it checks that staged data stays hidden until commit; a single-buffered design would show it at once.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;
  // Indices of the sampled pin vector.
  localparam int PIN_FRAME  = 0;
  localparam int PIN_BCLK   = 1;
  localparam int PIN_BDAT   = 2;
  localparam int PIN_STAGE  = 3;
  localparam int PIN_COMMIT = 4;
  localparam int PIN_PRESET = 5;
  localparam int PIN_MID    = 6;
  localparam int PIN_N      = 7;
  // Inactive level of each pin, loaded into the synchronizers at reset.
  localparam logic [PIN_N-1:0] PIN_IDLE = 7'b0111001;
endpackage

// File: rtl/qdac_pin_sync.sv
`timescale 1ns/1ps
module qdac_pin_sync #(
  parameter int unsigned W       = 7,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [STAGES-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
`timescale 1ns/1ps
module qdac_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_s_i,
  input  logic              bclk_s_i,
  input  logic              bdat_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              shift_o
);
  logic              comb_clk;
  logic              comb_q;
  logic              shift_en;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;

  always_comb begin
    comb_clk = frame_s_i | bclk_s_i;
    shift_en = comb_clk & ~comb_q;
    word_d   = {word_q[WORD_W-2:0], bdat_s_i};
  end

  // Previous level of the combined clock; idle frame is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comb_q <= 1'b1;
    else        comb_q <= comb_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= word_d;
  end

  assign word_o  = word_q;
  assign shift_o = shift_en;
endmodule

// File: rtl/qdac_regbank.sv
`timescale 1ns/1ps
module qdac_regbank #(
  parameter int unsigned CH_N   = 4,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stage_s_i,
  input  logic                     commit_s_i,
  input  logic                     preset_s_i,
  input  logic                     mid_s_i,
  input  logic [ADDR_W-1:0]        sel_i,
  input  logic [CODE_W-1:0]        code_i,
  output logic [CH_N*CODE_W-1:0]   stage_flat_o,
  output logic [CH_N*CODE_W-1:0]   out_flat_o,
  output logic [CH_N-1:0]          upd_o
);
  logic [CODE_W-1:0] preset_val;

  always_comb begin
    preset_val = {mid_s_i, {(CODE_W-1){1'b0}}};
  end

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    logic [CODE_W-1:0] stg_q, stg_d;
    logic [CODE_W-1:0] out_q, out_d;
    logic              stg_en, out_en;
    logic              upd_q, upd_d;

    always_comb begin
      stg_en = ~preset_s_i | (~stage_s_i & (sel_i == ADDR_W'(ch)));
      stg_d  = ~preset_s_i ? preset_val : code_i;
      out_en = ~preset_s_i | ~commit_s_i;
      out_d  = ~preset_s_i ? preset_val : stg_q;
      upd_d  = out_en & (out_d != out_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg_q <= '0;
      else if (stg_en) stg_q <= stg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (out_en) out_q <= out_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q <= 1'b0;
      else        upd_q <= upd_d;
    end

    assign stage_flat_o[ch*CODE_W +: CODE_W] = stg_q;
    assign out_flat_o[ch*CODE_W +: CODE_W]   = out_q;
    assign upd_o[ch]                         = upd_q;
  end
endmodule

// File: rtl/qdac_serial_frontend.sv
`timescale 1ns/1ps
module qdac_serial_frontend
  import qdac_pkg::*;
#(
  parameter int unsigned CH_N        = 4,
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned PAD_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_n_i,
  input  logic                   bit_clk_i,
  input  logic                   bit_dat_i,
  input  logic                   stage_n_i,
  input  logic                   commit_n_i,
  input  logic                   preset_n_i,
  input  logic                   preset_mid_i,
  output logic [CH_N*CODE_W-1:0] code_o,
  output logic [CH_N-1:0]        upd_o
);
  localparam int unsigned ADDR_W = (CH_N > 1) ? $clog2(CH_N) : 1;
  localparam int unsigned WORD_W = ADDR_W + PAD_W + CODE_W;

  logic [PIN_N-1:0]       pin_raw;
  logic [PIN_N-1:0]       pin_s;
  logic [WORD_W-1:0]      word_q;
  logic                   shift_en;
  logic [ADDR_W-1:0]      word_sel;
  logic [CODE_W-1:0]      word_code;
  logic [PAD_W-1:0]       pad_unused;
  logic [CH_N*CODE_W-1:0] stage_flat;
  logic                   frame_s, bclk_s, bdat_s, stage_s, commit_s, preset_s, mid_s;

  always_comb begin
    pin_raw             = '0;
    pin_raw[PIN_FRAME]  = frame_n_i;
    pin_raw[PIN_BCLK]   = bit_clk_i;
    pin_raw[PIN_BDAT]   = bit_dat_i;
    pin_raw[PIN_STAGE]  = stage_n_i;
    pin_raw[PIN_COMMIT] = commit_n_i;
    pin_raw[PIN_PRESET] = preset_n_i;
    pin_raw[PIN_MID]    = preset_mid_i;
  end

  qdac_pin_sync #(
    .W       (PIN_N),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  assign frame_s  = pin_s[PIN_FRAME];
  assign bclk_s   = pin_s[PIN_BCLK];
  assign bdat_s   = pin_s[PIN_BDAT];
  assign stage_s  = pin_s[PIN_STAGE];
  assign commit_s = pin_s[PIN_COMMIT];
  assign preset_s = pin_s[PIN_PRESET];
  assign mid_s    = pin_s[PIN_MID];

  qdac_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_s_i (frame_s),
    .bclk_s_i  (bclk_s),
    .bdat_s_i  (bdat_s),
    .word_o    (word_q),
    .shift_o   (shift_en)
  );

  assign word_sel   = word_q[WORD_W-1 -: ADDR_W];
  assign pad_unused = word_q[CODE_W +: PAD_W];
  assign word_code  = word_q[CODE_W-1:0];

  qdac_regbank #(
    .CH_N   (CH_N),
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .stage_s_i    (stage_s),
    .commit_s_i   (commit_s),
    .preset_s_i   (preset_s),
    .mid_s_i      (mid_s),
    .sel_i        (word_sel),
    .code_i       (word_code),
    .stage_flat_o (stage_flat),
    .out_flat_o   (code_o),
    .upd_o        (upd_o)
  );
endmodule

// File: rtl/qdac_chk.sv
`timescale 1ns/1ps
module qdac_chk #(
  parameter int unsigned CH_N   = 4,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned WORD_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   preset_s,
  input logic                   mid_s,
  input logic                   stage_s,
  input logic                   commit_s,
  input logic                   shift_en,
  input logic [WORD_W-1:0]      word_q,
  input logic [CH_N*CODE_W-1:0] stage_flat,
  input logic [CH_N*CODE_W-1:0] code_o,
  input logic [CH_N-1:0]        upd_o
);
  // R3: the shift register moves only on a detected combined-clock edge.
  assert_shift_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_q));

  // R4: staging registers hold while the staging strobe is high.
  assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_s && stage_s) |=> $stable(stage_flat));

  // R5: outputs hold while the commit strobe is high.
  assert_commit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_s && commit_s) |=> $stable(code_o));

  // R6: preset forces every output to the selected preset code.
  assert_preset_val_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_s |=> (code_o == {CH_N{$past(mid_s), {(CODE_W-1){1'b0}}}}));

  // R9: change pulse matches a code change, per channel.
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_upd
    assert_upd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o[ch] == (code_o[ch*CODE_W +: CODE_W] != $past(code_o[ch*CODE_W +: CODE_W])));
  end
endmodule

bind qdac_serial_frontend qdac_chk #(
  .CH_N   (CH_N),
  .CODE_W (CODE_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .preset_s   (preset_s),
  .mid_s      (mid_s),
  .stage_s    (stage_s),
  .commit_s   (commit_s),
  .shift_en   (shift_en),
  .word_q     (word_q),
  .stage_flat (stage_flat),
  .code_o     (code_o),
  .upd_o      (upd_o)
);

// File: tb/tb_qdac_serial_frontend.sv
`timescale 1ns/1ps
module tb_qdac_serial_frontend;
  logic        clk;
  logic        rst_n;
  logic        frame_n, bit_clk, bit_dat, stage_n, commit_n, preset_n, preset_mid;
  logic [47:0] code_o;
  logic [3:0]  upd_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  qdac_serial_frontend dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n_i    (frame_n),
    .bit_clk_i    (bit_clk),
    .bit_dat_i    (bit_dat),
    .stage_n_i    (stage_n),
    .commit_n_i   (commit_n),
    .preset_n_i   (preset_n),
    .preset_mid_i (preset_mid),
    .code_o       (code_o),
    .upd_o        (upd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  // Pins pass two sampling stages; each posedge then applies the rules
  // using the values visible before that edge.
  bit [6:0]  m_s1, m_s2;
  bit        m_prev;
  bit [15:0] m_sr;
  int        m_in[4];
  int        m_out[4];
  bit        m_upd[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 7'b0111001; m_s2 = 7'b0111001; m_prev = 1; m_sr = 0;
      foreach (m_in[i]) begin m_in[i] = 0; m_out[i] = 0; m_upd[i] = 0; end
    end else begin
      bit comb, rise, pre_low;
      int pv, sel, cval;
      int nin[4];
      int nout[4];
      comb    = m_s2[0] | m_s2[1];
      rise    = comb && !m_prev;
      pre_low = !m_s2[5];
      pv      = m_s2[6] ? 'h800 : 0;
      sel     = m_sr[15:14];
      cval    = m_sr[11:0];
      nin     = m_in;
      nout    = m_out;
      if (pre_low) foreach (nin[i]) nin[i] = pv;
      else if (!m_s2[3]) nin[sel] = cval;
      if (pre_low) foreach (nout[i]) nout[i] = pv;
      else if (!m_s2[4]) nout = m_in;
      foreach (nout[i]) m_upd[i] = (nout[i] != m_out[i]);
      m_in  = nin;
      m_out = nout;
      if (rise) m_sr = {m_sr[14:0], m_s2[2]};
      m_prev = comb;
      m_s2   = m_s1;
      m_s1   = {preset_mid, preset_n, commit_n, stage_n, bit_dat, bit_clk, frame_n};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int code_of(input int ch);
    return int'(code_o[ch*12 +: 12]);
  endfunction

  // Per-cycle comparison against the model (R5 codes, R9 pulses).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int ch = 0; ch < 4; ch++) begin
        chk(code_of(ch) == m_out[ch], $sformatf("R5 model ch%0d", ch), code_of(ch), m_out[ch]);
        chk(upd_o[ch] == m_upd[ch], $sformatf("R9 model ch%0d", ch), upd_o[ch], m_upd[ch]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_sck(input logic [15:0] w, input bit extra, input bit extra_bit);
    frame_n = 0; wait_cyc(4);
    for (int b = 15; b >= 0; b--) begin
      bit_dat = w[b]; bit_clk = 0; wait_cyc(4);
      bit_clk = 1; wait_cyc(4);
    end
    if (extra) begin
      bit_clk = 0; wait_cyc(4);
      bit_dat = extra_bit; wait_cyc(2);
      frame_n = 1; wait_cyc(4);
    end else begin
      frame_n = 1; wait_cyc(4);
      bit_clk = 0; wait_cyc(4);
    end
  endtask

  task automatic send_frame_clk(input logic [15:0] w);
    bit_clk = 0;
    for (int b = 15; b >= 0; b--) begin
      bit_dat = w[b]; frame_n = 0; wait_cyc(4);
      frame_n = 1; wait_cyc(4);
    end
  endtask

  task automatic pulse_stage();
    stage_n = 0; wait_cyc(6); stage_n = 1; wait_cyc(6);
  endtask

  task automatic pulse_commit();
    commit_n = 0; wait_cyc(6); commit_n = 1; wait_cyc(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; frame_n = 1; bit_clk = 0; bit_dat = 0;
    stage_n = 1; commit_n = 1; preset_n = 1; preset_mid = 0;
    wait_cyc(3);
    chk(code_o == 48'h0, "R1 reset codes", int'(code_o[31:0]), 0);
    chk(upd_o == 4'h0, "R1 reset pulses", upd_o, 0);
    rst_n = 1; wait_cyc(4);

    // R2/R5: stage channel 1 (ignored pad bits set), outputs must not move.
    send_sck({2'b01, 2'b11, 12'hABC}, 0, 0);
    pulse_stage();
    chk(code_of(1) == 0, "R5 staged data hidden before commit", code_of(1), 0);
    send_sck({2'b11, 2'b00, 12'h123}, 0, 0);
    pulse_stage();
    pulse_commit();
    chk(code_of(1) == 'hABC, "R2 channel 1 code", code_of(1), 'hABC);
    chk(code_of(3) == 'h123, "R2 channel 3 code", code_of(3), 'h123);
    chk(code_of(0) == 0, "R2 channel 0 untouched", code_of(0), 0);
    chk(code_of(2) == 0, "R2 channel 2 untouched", code_of(2), 0);

    // R4: commit held low; staging holds until strobe.
    commit_n = 0; wait_cyc(6);
    send_sck({2'b00, 2'b00, 12'h5A5}, 0, 0);
    chk(code_of(0) == 0, "R4 staging holds while strobe high", code_of(0), 0);
    pulse_stage();
    chk(code_of(0) == 'h5A5, "R4 transparent staging to output", code_of(0), 'h5A5);

    // R3: frame pin used as the shift clock.
    send_frame_clk({2'b10, 2'b01, 12'h3C6});
    pulse_stage();
    chk(code_of(2) == 'h3C6, "R3 frame-clocked word", code_of(2), 'h3C6);

    // R3: frame rises with bit clock low -> one extra shift.
    send_sck({2'b11, 2'b00, 12'h0F3}, 1, 1);
    pulse_stage();
    chk(code_of(2) == 'h1E7, "R3 extra shift lands on channel 2", code_of(2), 'h1E7);
    chk(code_of(3) == 'h123, "R3 extra shift spares channel 3", code_of(3), 'h123);

    // R6/R7: mid-scale preset, then release with strobes high.
    commit_n = 1; preset_mid = 1; wait_cyc(6);
    preset_n = 0; wait_cyc(6);
    for (int ch = 0; ch < 4; ch++)
      chk(code_of(ch) == 'h800, $sformatf("R6 mid preset ch%0d", ch), code_of(ch), 'h800);
    preset_n = 1; wait_cyc(8);
    for (int ch = 0; ch < 4; ch++)
      chk(code_of(ch) == 'h800, $sformatf("R7 preset kept ch%0d", ch), code_of(ch), 'h800);
    pulse_stage();
    chk(code_of(2) == 'h800, "R5 output holds after stage", code_of(2), 'h800);
    pulse_commit();
    chk(code_of(2) == 'h1E7, "R6 shift register survives preset", code_of(2), 'h1E7);
    chk(code_of(1) == 'h800, "R7 latched channel keeps preset", code_of(1), 'h800);
    preset_mid = 0; wait_cyc(4);
    preset_n = 0; wait_cyc(6); preset_n = 1; wait_cyc(6);
    for (int ch = 0; ch < 4; ch++)
      chk(code_of(ch) == 0, $sformatf("R6 zero preset ch%0d", ch), code_of(ch), 0);

    // R8: shifting with staging strobe low corrupts passed channels.
    commit_n = 0; stage_n = 0; wait_cyc(6);
    send_sck({2'b01, 2'b00, 12'hFFF}, 0, 0);
    stage_n = 1; wait_cyc(8);
    chk(code_of(1) == 'hFFF, "R8 final addressed channel", code_of(1), 'hFFF);
    chk(code_of(3) != 0, "R8 channel 3 corrupted in transit", code_of(3), 1);
    commit_n = 1; wait_cyc(8);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule